// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer with Jump-and-Link

This block is the control sequencer of a 32-bit multicycle RISC datapath. On every clock it takes the 6-bit opcode of the instruction held in the instruction register. It moves through a 4-bit step number and drives the multiplexer selects and write enables that the datapath needs for the current step.

Instruction fetch and decode are shared by all instructions. After decode the sequencer branches into one of several paths:

- the load path and the store path;
- the register-to-register ALU path;
- the conditional branch step;
- the unconditional jump step;
- a dedicated link step for jump-and-link.

The link step writes the already-incremented program counter into register 31 and loads the jump target in the same cycle. To support it, the destination-register select and the write-back-data select are each two bits wide and choose among three sources.

Each next-step bit is formed by its own sum-of-products equation over decoded step and opcode terms. The step number and every control output are registered. The outputs of a cycle therefore always belong to the step shown on `state_o`.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `state_o` is 0 (fetch). In step 0 the outputs are `pc_wr`=1, `pc_sel`=00, `mem_rd`=1, `ir_wr`=1, `alub_sel`=01 and `alu_mode`=00.
- R2: Step 0 always goes to step 1 (decode). In step 1 the only nonzero control is `alub_sel`=11.
- R3: Opcode 100011 (load) runs steps 0,1,2,3,4,0. Opcode 101011 (store) runs steps 0,1,2,5,0.
  - Step 2 drives `alua_sel`=1 and `alub_sel`=10.
  - Step 3 drives `mem_rd`=1 and `addr_sel`=1.
  - Step 4 drives `rf_wr`=1, `dst_sel`=00 and `wb_sel`=01.
  - Step 5 drives `mem_wr`=1 and `addr_sel`=1.
- R4: Opcode 000000 (register type) runs steps 0,1,6,7,0.
  - Step 6 drives `alua_sel`=1, `alub_sel`=00 and `alu_mode`=10.
  - Step 7 drives `rf_wr`=1, `dst_sel`=01 and `wb_sel`=00.
- R5: Opcode 000100 (branch if equal) runs steps 0,1,8,0. Step 8 drives `pc_wr_cond`=1, `pc_sel`=01, `alua_sel`=1 and `alu_mode`=01.
- R6: Opcode 000010 (jump) runs steps 0,1,9,0. Step 9 drives `pc_wr`=1 and `pc_sel`=10, and `rf_wr` stays 0.
- R7: Opcode 000011 (jump-and-link) in step 1 selects step 10 as the next step.
- R8: Step 10 drives all of the following:
  - `pc_wr`=1 and `pc_sel`=10 (jump target);
  - `rf_wr`=1;
  - `dst_sel`=10 (register 31);
  - `wb_sel`=10 (incremented PC).
- R9: Step 10 returns to step 0 on the next clock.
- R10: In step 1, an opcode outside the six listed above returns the sequencer to step 0.
- R11: The opcode is ignored in every step other than 1 and 2. Changing it while in steps 0, 3 or 4 does not alter the step sequence.
- R12: Any control not listed for a step is 0 in that step. `mem_rd` and `mem_wr` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the held instruction |
| state_o | output | 4 | Current step number |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write qualified by ALU zero |
| pc_sel | output | 2 | PC source: 00 ALU, 01 ALU result register, 10 jump target |
| addr_sel | output | 2 | Memory address source: 0 PC, 1 ALU result register (bit 0 used) |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_wr | output | 1 | Instruction register load |
| dst_sel | output | 2 | Destination register: 00 rt, 01 rd, 10 register 31 |
| wb_sel | output | 2 | Write-back data: 00 ALU result, 01 memory data, 10 PC+4 |
| rf_wr | output | 1 | Register file write |
| alua_sel | output | 1 | ALU A operand: 0 PC, 1 register A |
| alub_sel | output | 2 | ALU B operand: 00 register B, 01 constant 4, 10 immediate, 11 shifted immediate |
| alu_mode | output | 2 | ALU operation class: 00 add, 01 subtract, 10 function field |

## Verification
The step register and the control register both load on the same rising edge. The step and controls for a new step are therefore due exactly one clock after the edge on which the previous step and opcode were present. An opcode applied while the sequencer sits in decode shows its effect on the following edge.

The bench changes the opcode only on falling edges. After each single rising edge it checks `state_o` and the full control vector at the next falling edge, so every check sees the values of exactly one step. The ignore test changes the opcode between two such samples while in steps 0, 3 and 4. It then confirms the next sampled step is the one the earlier opcode dictated.

// File: rtl/mcf_pkg.sv
package mcf_pkg;
  localparam int STATE_W = 4;
  localparam int OP_W    = 6;
  localparam int SEL_W   = 2;

  localparam logic [STATE_W-1:0] ST_FETCH  = 4'd0;
  localparam logic [STATE_W-1:0] ST_DECODE = 4'd1;
  localparam logic [STATE_W-1:0] ST_MADDR  = 4'd2;
  localparam logic [STATE_W-1:0] ST_MREAD  = 4'd3;
  localparam logic [STATE_W-1:0] ST_LDWB   = 4'd4;
  localparam logic [STATE_W-1:0] ST_MWRITE = 4'd5;
  localparam logic [STATE_W-1:0] ST_EXEC   = 4'd6;
  localparam logic [STATE_W-1:0] ST_RWB    = 4'd7;
  localparam logic [STATE_W-1:0] ST_BRANCH = 4'd8;
  localparam logic [STATE_W-1:0] ST_JUMP   = 4'd9;
  localparam logic [STATE_W-1:0] ST_LINK   = 4'd10;

  localparam logic [OP_W-1:0] OP_RTYPE = 6'b000000;
  localparam logic [OP_W-1:0] OP_LOAD  = 6'b100011;
  localparam logic [OP_W-1:0] OP_STORE = 6'b101011;
  localparam logic [OP_W-1:0] OP_BEQ   = 6'b000100;
  localparam logic [OP_W-1:0] OP_JMP   = 6'b000010;
  localparam logic [OP_W-1:0] OP_JLINK = 6'b000011;

  typedef struct packed {
    logic             pc_wr;
    logic             pc_wr_cond;
    logic [SEL_W-1:0] pc_sel;
    logic             addr_sel;
    logic             mem_rd;
    logic             mem_wr;
    logic             ir_wr;
    logic [SEL_W-1:0] dst_sel;
    logic [SEL_W-1:0] wb_sel;
    logic             rf_wr;
    logic             alua_sel;
    logic [SEL_W-1:0] alub_sel;
    logic [SEL_W-1:0] alu_mode;
  } ctrl_t;
endpackage

// File: rtl/mcf_next_state.sv
module mcf_next_state
  import mcf_pkg::*;
(
  input  logic [STATE_W-1:0] state,
  input  logic [OP_W-1:0]    opcode,
  output logic [STATE_W-1:0] next_state
);
  logic in_fetch, in_decode, in_maddr, in_mread, in_exec;
  logic op_r, op_ld, op_st, op_beq, op_j, op_jl;

  assign in_fetch  = (state == ST_FETCH);
  assign in_decode = (state == ST_DECODE);
  assign in_maddr  = (state == ST_MADDR);
  assign in_mread  = (state == ST_MREAD);
  assign in_exec   = (state == ST_EXEC);

  assign op_r   = (opcode == OP_RTYPE);
  assign op_ld  = (opcode == OP_LOAD);
  assign op_st  = (opcode == OP_STORE);
  assign op_beq = (opcode == OP_BEQ);
  assign op_j   = (opcode == OP_JMP);
  assign op_jl  = (opcode == OP_JLINK);

  // One product term per transition that sets the bit; unlisted steps fall to 0
  assign next_state[0] = in_fetch
                       | (in_maddr  & op_ld)
                       | (in_maddr  & op_st)
                       | in_exec
                       | (in_decode & op_j);
  assign next_state[1] = (in_decode & op_ld)
                       | (in_decode & op_st)
                       | (in_maddr  & op_ld)
                       | (in_decode & op_r)
                       | in_exec
                       | (in_decode & op_jl);
  assign next_state[2] = in_mread
                       | (in_maddr  & op_st)
                       | (in_decode & op_r)
                       | in_exec;
  assign next_state[3] = (in_decode & op_beq)
                       | (in_decode & op_j)
                       | (in_decode & op_jl);
endmodule

// File: rtl/mcf_ctrl_decode.sv
module mcf_ctrl_decode
  import mcf_pkg::*;
(
  input  logic [STATE_W-1:0] state,
  output ctrl_t              ctrl
);
  always_comb begin
    ctrl = '0;
    case (state)
      ST_FETCH: begin
        ctrl.pc_wr    = 1'b1;
        ctrl.mem_rd   = 1'b1;
        ctrl.ir_wr    = 1'b1;
        ctrl.alub_sel = 2'b01;
      end
      ST_DECODE: ctrl.alub_sel = 2'b11;
      ST_MADDR: begin
        ctrl.alua_sel = 1'b1;
        ctrl.alub_sel = 2'b10;
      end
      ST_MREAD: begin
        ctrl.mem_rd   = 1'b1;
        ctrl.addr_sel = 1'b1;
      end
      ST_LDWB: begin
        ctrl.rf_wr  = 1'b1;
        ctrl.wb_sel = 2'b01;
      end
      ST_MWRITE: begin
        ctrl.mem_wr   = 1'b1;
        ctrl.addr_sel = 1'b1;
      end
      ST_EXEC: begin
        ctrl.alua_sel = 1'b1;
        ctrl.alu_mode = 2'b10;
      end
      ST_RWB: begin
        ctrl.rf_wr   = 1'b1;
        ctrl.dst_sel = 2'b01;
      end
      ST_BRANCH: begin
        ctrl.pc_wr_cond = 1'b1;
        ctrl.pc_sel     = 2'b01;
        ctrl.alua_sel   = 1'b1;
        ctrl.alu_mode   = 2'b01;
      end
      ST_JUMP: begin
        ctrl.pc_wr  = 1'b1;
        ctrl.pc_sel = 2'b10;
      end
      ST_LINK: begin
        ctrl.pc_wr   = 1'b1;
        ctrl.pc_sel  = 2'b10;
        ctrl.rf_wr   = 1'b1;
        ctrl.dst_sel = 2'b10;
        ctrl.wb_sel  = 2'b10;
      end
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
  import mcf_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [OP_W-1:0]    opcode,
  output logic [STATE_W-1:0] state_o,
  output logic               pc_wr,
  output logic               pc_wr_cond,
  output logic [SEL_W-1:0]   pc_sel,
  output logic [SEL_W-1:0]   addr_sel,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic               ir_wr,
  output logic [SEL_W-1:0]   dst_sel,
  output logic [SEL_W-1:0]   wb_sel,
  output logic               rf_wr,
  output logic               alua_sel,
  output logic [SEL_W-1:0]   alub_sel,
  output logic [SEL_W-1:0]   alu_mode
);
  logic [STATE_W-1:0] state_q, ns_d, dec_in;
  ctrl_t              ctrl_d, ctrl_q;

  mcf_next_state u_next (
    .state      (state_q),
    .opcode     (opcode),
    .next_state (ns_d)
  );

  // Decode the step about to be entered so the control register lines up with it
  assign dec_in = rst ? ST_FETCH : ns_d;

  mcf_ctrl_decode u_dec (
    .state (dec_in),
    .ctrl  (ctrl_d)
  );

  always_ff @(posedge clk) begin
    state_q <= dec_in;
    ctrl_q  <= ctrl_d;
  end

  assign state_o    = state_q;
  assign pc_wr      = ctrl_q.pc_wr;
  assign pc_wr_cond = ctrl_q.pc_wr_cond;
  assign pc_sel     = ctrl_q.pc_sel;
  assign addr_sel   = {1'b0, ctrl_q.addr_sel};
  assign mem_rd     = ctrl_q.mem_rd;
  assign mem_wr     = ctrl_q.mem_wr;
  assign ir_wr      = ctrl_q.ir_wr;
  assign dst_sel    = ctrl_q.dst_sel;
  assign wb_sel     = ctrl_q.wb_sel;
  assign rf_wr      = ctrl_q.rf_wr;
  assign alua_sel   = ctrl_q.alua_sel;
  assign alub_sel   = ctrl_q.alub_sel;
  assign alu_mode   = ctrl_q.alu_mode;

  AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_FETCH) |=> (state_o == ST_DECODE)); // R2
  AST_LINK_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_DECODE && opcode == OP_JLINK) |=> (state_o == ST_LINK)); // R7
  AST_LINK_CONTROLS: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_LINK) |-> (pc_wr && rf_wr && pc_sel == 2'b10 && dst_sel == 2'b10 && wb_sel == 2'b10)); // R8
  AST_LINK_EXIT: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_LINK) |=> (state_o == ST_FETCH)); // R9
  AST_RTYPE_EXEC: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_DECODE && opcode == OP_RTYPE) |=> (state_o == ST_EXEC)); // R4
  AST_MEM_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr)); // R12
  AST_JUMP_NO_REGWRITE: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_JUMP) |-> !rf_wr); // R6
endmodule

// File: tb/mc_ctrl_fsm_bench.sv
module mc_ctrl_fsm_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 5000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'b111111;
  logic [3:0] state_o;
  logic       pc_wr, pc_wr_cond, mem_rd, mem_wr, ir_wr, rf_wr, alua_sel;
  logic [1:0] pc_sel, addr_sel, dst_sel, wb_sel, alub_sel, alu_mode;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_ctrl_fsm u_mc_ctrl_fsm (
    .clk(clk), .rst(rst), .opcode(opcode), .state_o(state_o),
    .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .pc_sel(pc_sel),
    .addr_sel(addr_sel), .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr),
    .dst_sel(dst_sel), .wb_sel(wb_sel), .rf_wr(rf_wr), .alua_sel(alua_sel),
    .alub_sel(alub_sel), .alu_mode(alu_mode)
  );

  // {pc_wr,pc_wr_cond,pc_sel,addr_sel,mem_rd,mem_wr,ir_wr,dst_sel,wb_sel,rf_wr,alua_sel,alub_sel,alu_mode}
  function automatic logic [18:0] exp_ctrl(input logic [3:0] s);
    logic pw = 0, pwc = 0, mr = 0, mw = 0, iw = 0, rw = 0, aa = 0;
    logic [1:0] ps = 0, ad = 0, ds = 0, ws = 0, ab = 0, am = 0;
    case (s)
      4'd0:  begin pw = 1; mr = 1; iw = 1; ab = 2'b01; end
      4'd1:  ab = 2'b11;
      4'd2:  begin aa = 1; ab = 2'b10; end
      4'd3:  begin mr = 1; ad = 2'b01; end
      4'd4:  begin rw = 1; ws = 2'b01; end
      4'd5:  begin mw = 1; ad = 2'b01; end
      4'd6:  begin aa = 1; am = 2'b10; end
      4'd7:  begin rw = 1; ds = 2'b01; end
      4'd8:  begin pwc = 1; ps = 2'b01; aa = 1; am = 2'b01; end
      4'd9:  begin pw = 1; ps = 2'b10; end
      4'd10: begin pw = 1; ps = 2'b10; rw = 1; ds = 2'b10; ws = 2'b10; end
      default: ;
    endcase
    return {pw, pwc, ps, ad, mr, mw, iw, ds, ws, rw, aa, ab, am};
  endfunction

  function automatic logic [18:0] got_ctrl();
    return {pc_wr, pc_wr_cond, pc_sel, addr_sel, mem_rd, mem_wr, ir_wr,
            dst_sel, wb_sel, rf_wr, alua_sel, alub_sel, alu_mode};
  endfunction

  task automatic check_step(input string tag, input logic [3:0] exp_s);
    n_chk++;
    if (state_o !== exp_s) begin
      n_bad++;
      $display("FAIL %s state: actual %0d expected %0d", tag, state_o, exp_s);
    end
    n_chk++;
    if (got_ctrl() !== exp_ctrl(exp_s)) begin
      n_bad++;
      $display("FAIL %s controls in step %0d: actual %b expected %b",
               tag, exp_s, got_ctrl(), exp_ctrl(exp_s));
    end
    n_chk++;
    if (mem_rd && mem_wr) begin
      n_bad++;
      $display("FAIL R12 mem_rd/mem_wr: actual 11 expected not both");
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // path holds the steps after fetch, nibble 0 first; sequence must start in step 0
  task automatic walk(input string tag, input logic [5:0] op,
                      input logic [23:0] path, input int len);
    opcode = op;
    for (int i = 0; i < len; i++) begin
      tick();
      check_step(tag, path[4*i +: 4]);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) tick();
    check_step("R1 in reset", 4'd0);
    rst = 1'b0;
    check_step("R1 after reset", 4'd0);
  endtask

  task automatic t_load();  walk("R3 load",  6'b100011, {4'd0, 4'd4, 4'd3, 4'd2, 4'd1}, 5); endtask
  task automatic t_store(); walk("R3 store", 6'b101011, {4'd0, 4'd5, 4'd2, 4'd1}, 4); endtask
  task automatic t_rtype(); walk("R4 rtype", 6'b000000, {4'd0, 4'd7, 4'd6, 4'd1}, 4); endtask
  task automatic t_branch(); walk("R5 branch", 6'b000100, {4'd0, 4'd8, 4'd1}, 3); endtask
  task automatic t_jump();  walk("R6 jump",  6'b000010, {4'd0, 4'd9, 4'd1}, 3); endtask

  task automatic t_link();
    opcode = 6'b000011;
    tick(); check_step("R2 decode", 4'd1);
    tick(); check_step("R7 enter link", 4'd10);
    check_step("R8 link controls", 4'd10);
    tick(); check_step("R9 link exit", 4'd0);
  endtask

  task automatic t_unknown();
    walk("R10 bad opcode 111111", 6'b111111, {4'd0, 4'd1}, 2);
    walk("R10 bad opcode 001000", 6'b001000, {4'd0, 4'd1}, 2);
  endtask

  task automatic t_ignore();
    opcode = 6'b100011;
    tick(); check_step("R11 load decode", 4'd1);
    tick(); check_step("R11 load addr", 4'd2);
    tick(); check_step("R11 load read", 4'd3);
    opcode = 6'b000011;
    tick(); check_step("R11 ignore in step 3", 4'd4);
    opcode = 6'b000000;
    tick(); check_step("R11 ignore in step 4", 4'd0);
    opcode = 6'b000011;
    tick(); check_step("R11 ignore in step 0", 4'd1);
    tick(); check_step("R11 link after change", 4'd10);
    tick(); check_step("R12 back to fetch", 4'd0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_load();
    t_store();
    t_rtype();
    t_branch();
    t_jump();
    t_link();
    t_unknown();
    t_ignore();
    t_link();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule